// File: doc/BRIEF.md
# Synchronized Edge and Level Interrupt Bank

This block watches eight asynchronous external inputs, brings each of them into the system clock domain through a two-flop synchroniser, and turns selected events on those inputs into one interrupt line. Each channel picks its own trigger type from three configuration bits: a detection-kind bit (edge or level), a polarity bit, and an any-transition bit. Together these bits cover rising edge, falling edge, both edges, high level and low level.

Software reaches the block over a simple register bus with an address, a write strobe, write data and combinational read data. There are eight word registers. Four hold the per-channel configuration: the interrupt enable, the detection kind, the any-transition selection and the polarity. A sticky raw status register records every event detected. A masked view ANDs the raw status with the enables, and a write-one-to-clear port drops status bits. A data register shows the synchronised input levels. The interrupt output is high whenever any masked bit is set.

Top module: `sync_irq_bank`

## Requirements
- R1: After reset every readable register returns zero and irq_o is low.
- R2: The data register at byte offset 0x1C returns the synchronised input levels in bits 7:0, so a change on ext_in shows there after two rising clock edges.
- R3: With kind bit 0 (edge), any-transition bit 0 and polarity bit 1, a channel's raw status bit (offset 0x04, bit = channel) is set by a 0-to-1 transition and not by a 1-to-0 transition.
- R4: With kind bit 0, any-transition bit 0 and polarity bit 0, only a 1-to-0 transition sets the raw bit.
- R5: With kind bit 0 and the any-transition bit (offset 0x14) at 1, both directions set the raw bit, whatever the polarity bit (offset 0x18) holds.
- R6: With the kind bit (offset 0x10) at 1, the raw bit is set on every cycle in which the synchronised level equals the polarity bit, so it comes back after a clear while that level persists. The any-transition bit has no effect in this mode.
- R7: Writing 1 to a bit of the clear register (offset 0x0C) drops that raw bit. Writing 0 leaves it unchanged. When a new event lands in the same cycle as the clear, the bit stays set. The clear register reads as zero.
- R8: The masked register (offset 0x08) equals raw AND enable (offset 0x00), and irq_o is the OR of the masked bits.
- R9: A raw bit is set at the third rising clock edge after the input change that causes it, and never without a detected event.
- R10: The configuration registers read back their low 8 bits with the upper bits zero. Writes to the raw, masked and data offsets and to unaligned addresses change nothing, and unaligned addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ext_in | input | 8 | Asynchronous channel inputs |
| irq_o | output | 1 | Combined interrupt request |

## Verification
An input change reaches the data register two rising edges later and the raw status on the third. irq_o and the masked view follow raw in the same cycle, with no extra register. Register writes take effect at the edge on which bus_wr is sampled. A behavioural model in the bench keeps a short history of ext_in as sampled at each edge and applies each event at that third-edge offset. The bench samples outputs on the falling edge and compares them with the model on every cycle. Directed checks drive inputs just after a falling edge and count falling edges exactly for the latency and same-cycle clear cases.

// File: rtl/sib_pkg.sv
package sib_pkg;

   // Word index of each register (byte address bits 4:2); software decodes these
   typedef enum logic [2:0] {
      REG_EN   = 3'd0,
      REG_RAW  = 3'd1,
      REG_MSK  = 3'd2,
      REG_CLR  = 3'd3,
      REG_MODE = 3'd4,
      REG_BOTH = 3'd5,
      REG_POL  = 3'd6,
      REG_DATA = 3'd7
   } sib_reg_e;

   // Number of address bits that select a word inside the map
   localparam int unsigned MAP_LSB = 2;
   localparam int unsigned MAP_MSB = 4;
   localparam int unsigned MAP_BITS = MAP_MSB + 1;

   // Writable configuration slots held in one array
   localparam int unsigned CFG_SLOTS = 4;
   localparam int unsigned SLOT_EN   = 0;
   localparam int unsigned SLOT_MODE = 1;
   localparam int unsigned SLOT_BOTH = 2;
   localparam int unsigned SLOT_POL  = 3;

   // Trigger selection of one channel
   typedef struct packed {
      logic lvl;   // 1: level detection, 0: edge detection
      logic any;   // edge detection on both transitions
      logic pol;   // 1: high / rising, 0: low / falling
   } sib_trig_t;

   function automatic sib_reg_e slot_reg(input int unsigned slot);
      case (slot)
         SLOT_EN:   return REG_EN;
         SLOT_MODE: return REG_MODE;
         SLOT_BOTH: return REG_BOTH;
         default:   return REG_POL;
      endcase
   endfunction

endpackage

// File: rtl/sib_sync.sv
module sib_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_async;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sib_detect.sv
module sib_detect
   import sib_pkg::*;
#(
   parameter int unsigned NCH = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] lvl,
   input  logic [NCH-1:0] cfg_mode,
   input  logic [NCH-1:0] cfg_both,
   input  logic [NCH-1:0] cfg_pol,
   output logic [NCH-1:0] hit
);

   logic [NCH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
      end else begin
         prev_q <= lvl;
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      sib_trig_t trig;
      logic      rise;
      logic      fall;
      logic      edge_hit;
      logic      level_hit;

      assign trig      = '{lvl: cfg_mode[c], any: cfg_both[c], pol: cfg_pol[c]};
      assign rise      = lvl[c] & ~prev_q[c];
      assign fall      = ~lvl[c] & prev_q[c];
      assign edge_hit  = trig.any ? (rise | fall) : (trig.pol ? rise : fall);
      assign level_hit = (lvl[c] == trig.pol);
      assign hit[c]    = trig.lvl ? level_hit : edge_hit;
   end

endmodule

// File: rtl/sib_regs.sv
module sib_regs
   import sib_pkg::*;
#(
   parameter int unsigned NCH    = 8,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [NCH-1:0]    wdata,
   input  logic [NCH-1:0]    hit,
   input  logic [NCH-1:0]    lvl,
   output logic [NCH-1:0]    en_o,
   output logic [NCH-1:0]    mode_o,
   output logic [NCH-1:0]    both_o,
   output logic [NCH-1:0]    pol_o,
   output logic [NCH-1:0]    raw_o,
   output logic [NCH-1:0]    masked_o,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned HI_W = ADDR_W - MAP_BITS;

   logic                           in_map;
   sib_reg_e                       idx;
   logic [CFG_SLOTS-1:0][NCH-1:0]  cfg_q;
   logic [NCH-1:0]                 raw_q;
   logic [NCH-1:0]                 clr_mask;
   logic [NCH-1:0]                 rd_bits;

   assign idx = sib_reg_e'(addr[MAP_MSB:MAP_LSB]);

   if (HI_W > 0) begin : g_hi_decode
      assign in_map = (addr[ADDR_W-1:MAP_BITS] == '0) && (addr[MAP_LSB-1:0] == '0);
   end else begin : g_flat_decode
      assign in_map = (addr[MAP_LSB-1:0] == '0);
   end

   // Configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         for (int unsigned s = 0; s < CFG_SLOTS; s++) begin
            if (wr_en && in_map && (idx == slot_reg(s))) begin
               cfg_q[s] <= wdata;
            end
         end
      end
   end

   // Write-one-to-clear, new events take priority
   assign clr_mask = (wr_en && in_map && (idx == REG_CLR)) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
      end else begin
         raw_q <= (raw_q & ~clr_mask) | hit;
      end
   end

   assign en_o     = cfg_q[SLOT_EN];
   assign mode_o   = cfg_q[SLOT_MODE];
   assign both_o   = cfg_q[SLOT_BOTH];
   assign pol_o    = cfg_q[SLOT_POL];
   assign raw_o    = raw_q;
   assign masked_o = raw_q & cfg_q[SLOT_EN];

   always_comb begin
      rd_bits = '0;
      if (in_map) begin
         case (idx)
            REG_EN:   rd_bits = cfg_q[SLOT_EN];
            REG_RAW:  rd_bits = raw_q;
            REG_MSK:  rd_bits = raw_q & cfg_q[SLOT_EN];
            REG_CLR:  rd_bits = '0;
            REG_MODE: rd_bits = cfg_q[SLOT_MODE];
            REG_BOTH: rd_bits = cfg_q[SLOT_BOTH];
            REG_POL:  rd_bits = cfg_q[SLOT_POL];
            REG_DATA: rd_bits = lvl;
            default:  rd_bits = '0;
         endcase
      end
   end

   assign rdata = DATA_W'(rd_bits);

endmodule

// File: rtl/sync_irq_bank.sv
module sync_irq_bank
   import sib_pkg::*;
#(
   parameter int unsigned NCH         = 8,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NCH-1:0]    ext_in,
   output logic              irq_o
);

   // Elaboration-time parameter checks
   if (NCH < 1 || NCH > DATA_W) begin : g_bad_nch
      $error("sync_irq_bank: NCH must be 1..DATA_W");
   end
   if (ADDR_W < MAP_BITS) begin : g_bad_addr
      $error("sync_irq_bank: ADDR_W too small for the register map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sync_irq_bank: at least two synchroniser stages are required");
   end

   logic [NCH-1:0] sync_lvl;
   logic [NCH-1:0] hit;
   logic [NCH-1:0] en_vec;
   logic [NCH-1:0] mode_vec;
   logic [NCH-1:0] both_vec;
   logic [NCH-1:0] pol_vec;
   logic [NCH-1:0] raw_vec;
   logic [NCH-1:0] masked_vec;

   if (DATA_W > NCH) begin : g_wide_bus
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NCH];
   end

   sib_sync #(
      .WIDTH  (NCH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (ext_in),
      .q_sync  (sync_lvl)
   );

   sib_detect #(
      .NCH (NCH)
   ) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (sync_lvl),
      .cfg_mode (mode_vec),
      .cfg_both (both_vec),
      .cfg_pol  (pol_vec),
      .hit      (hit)
   );

   sib_regs #(
      .NCH    (NCH),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .wr_en    (bus_wr),
      .wdata    (bus_wdata[NCH-1:0]),
      .hit      (hit),
      .lvl      (sync_lvl),
      .en_o     (en_vec),
      .mode_o   (mode_vec),
      .both_o   (both_vec),
      .pol_o    (pol_vec),
      .raw_o    (raw_vec),
      .masked_o (masked_vec),
      .rdata    (bus_rdata)
   );

   assign irq_o = |masked_vec;

endmodule

// File: rtl/sib_checker.sv
module sib_checker
   import sib_pkg::*;
#(
   parameter int unsigned NCH    = 8,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [NCH-1:0]    wdata,
   input logic [NCH-1:0]    pins,
   input logic              irq,
   input logic [NCH-1:0]    raw,
   input logic [NCH-1:0]    en,
   input logic [NCH-1:0]    mode,
   input logic [NCH-1:0]    pol,
   input logic [NCH-1:0]    hit,
   input logic [NCH-1:0]    sync
);

   localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(int'(REG_CLR) << MAP_LSB);

   logic [1:0]     cyc_q;
   logic [NCH-1:0] clr_now;
   logic [NCH-1:0] lvl_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
      end else if (cyc_q != 2'd3) begin
         cyc_q <= cyc_q + 2'd1;
      end
   end

   assign clr_now    = (wr_en && addr == CLR_ADDR) ? wdata : '0;
   assign lvl_active = mode & ~(sync ^ pol);

   // R2: synchroniser output lags the pins by two edges
   p_data_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q >= 2'd2) |-> (sync == $past(pins, 2)));

   // R6: an active level always leaves its raw bit set on the next cycle
   p_level_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q >= 2'd1) |=> (($past(lvl_active) & ~raw) == '0));

   // R7: a written clear drops every bit that saw no new event
   p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q >= 2'd1) |=> ((raw & $past(clr_now) & ~$past(hit)) == '0));

   // R7: raw bits are sticky unless cleared
   p_raw_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q >= 2'd1) |=> (($past(raw) & ~$past(clr_now) & ~raw) == '0));

   // R9: a raw bit only rises on a detected event
   p_rise_needs_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q >= 2'd1) |=> ((raw & ~$past(raw) & ~$past(hit)) == '0));

   // R8: no enables, no interrupt; an enabled raw bit raises it
   p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq);
   p_irq_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw & en) != '0) |-> irq);

endmodule

bind sync_irq_bank sib_checker #(
   .NCH    (NCH),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .addr  (bus_addr),
   .wr_en (bus_wr),
   .wdata (bus_wdata[NCH-1:0]),
   .pins  (ext_in),
   .irq   (irq_o),
   .raw   (raw_vec),
   .en    (en_vec),
   .mode  (mode_vec),
   .pol   (pol_vec),
   .hit   (hit),
   .sync  (sync_lvl)
);

// File: tb/sync_irq_bank_tb.sv
module sync_irq_bank_tb;

   localparam int NCH = 8;
   localparam int AW  = 5;
   localparam int DW  = 32;
   localparam int WATCHDOG = 200000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [7:0]    ext_in = '0;
   logic          irq_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit chk_on   = 0;

   always #10 clk = ~clk;

   sync_irq_bank #(.NCH(NCH), .ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in), .irq_o(irq_o)
   );

   // Behavioural reference: history of pin samples, event applied at the third edge
   logic [7:0] m_h0, m_h1, m_h2;
   logic [7:0] m_en, m_mode, m_both, m_pol, m_raw;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_h0 = 0; m_h1 = 0; m_h2 = 0;
         m_en = 0; m_mode = 0; m_both = 0; m_pol = 0; m_raw = 0;
      end else begin
         logic [7:0] ev;
         logic [7:0] clr;
         ev = 0;
         for (int c = 0; c < 8; c++) begin
            bit now_v, old_v;
            now_v = m_h1[c];
            old_v = m_h2[c];
            if (m_mode[c]) ev[c] = (now_v == m_pol[c]);
            else if (m_both[c]) ev[c] = (now_v != old_v);
            else if (m_pol[c]) ev[c] = now_v && !old_v;
            else ev[c] = !now_v && old_v;
         end
         clr = (bus_wr && bus_addr == 5'h0C) ? bus_wdata[7:0] : 8'h00;
         m_raw = (m_raw & ~clr) | ev;
         if (bus_wr) begin
            case (bus_addr)
               5'h00: m_en   = bus_wdata[7:0];
               5'h10: m_mode = bus_wdata[7:0];
               5'h14: m_both = bus_wdata[7:0];
               5'h18: m_pol  = bus_wdata[7:0];
               default: ;
            endcase
         end
         m_h2 = m_h1; m_h1 = m_h0; m_h0 = ext_in;
      end
   end

   function automatic logic [31:0] model_read(input logic [4:0] a);
      case (a)
         5'h00: return {24'd0, m_en};
         5'h04: return {24'd0, m_raw};
         5'h08: return {24'd0, m_raw & m_en};
         5'h10: return {24'd0, m_mode};
         5'h14: return {24'd0, m_both};
         5'h18: return {24'd0, m_pol};
         5'h1C: return {24'd0, m_h1};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string addr_tag(input logic [4:0] a);
      case (a)
         5'h04: return "R9";
         5'h08: return "R8";
         5'h0C: return "R7";
         5'h1C: return "R2";
         default: return "R10";
      endcase
   endfunction

   // Cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (chk_on) begin
         logic [31:0] exp_rd;
         exp_rd = model_read(bus_addr);
         n_checks++;
         if (bus_rdata !== exp_rd) begin
            n_fails++;
            $display("FAIL %s model rdata @%h actual %h expected %h",
                     addr_tag(bus_addr), bus_addr, bus_rdata, exp_rd);
         end
         n_checks++;
         if (irq_o !== ((m_raw & m_en) != 0)) begin
            n_fails++;
            $display("FAIL R8 model irq actual %b expected %b", irq_o, (m_raw & m_en) != 0);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic chk_now(input logic [31:0] exp, input string tag);
      n_checks++;
      if (bus_rdata !== exp) begin
         n_fails++;
         $display("FAIL %s rdata @%h actual %h expected %h", tag, bus_addr, bus_rdata, exp);
      end
   endtask

   task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); #1;
      bus_addr = a;
      @(negedge clk);
      chk_now(exp, tag);
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      @(negedge clk);
      n_checks++;
      if (irq_o !== exp) begin
         n_fails++;
         $display("FAIL %s irq actual %b expected %b", tag, irq_o, exp);
      end
   endtask

   task automatic set_pins(input logic [7:0] v);
      @(negedge clk); #1;
      ext_in = v;
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      chk_on = 1;

      // R1: reset state
      for (int a = 0; a < 32; a += 4) rd(5'(a), 32'h0, "R1");
      chk_irq(1'b0, "R1");

      // R2: synchronised data
      set_pins(8'hA5); idle(4);
      rd(5'h1C, 32'hA5, "R2");
      rd(5'h04, 32'h00, "R4 rising ignored");

      // R4: falling edges with polarity 0
      set_pins(8'h00); idle(4);
      rd(5'h04, 32'hA5, "R4");

      // R3 and R9: rising edge latency
      wr(5'h18, 32'hFF);
      wr(5'h0C, 32'hFF);
      rd(5'h04, 32'h00, "R7 clear all");
      @(negedge clk); #1;
      bus_addr = 5'h04; ext_in = 8'h01;
      @(negedge clk);
      @(negedge clk); chk_now(32'h00, "R9 not before third edge");
      @(negedge clk); chk_now(32'h01, "R9 R3 set at third edge");
      set_pins(8'h00); idle(4);
      rd(5'h04, 32'h01, "R3 falling ignored");

      // R5: both edges, polarity ignored
      wr(5'h14, 32'h0C);
      wr(5'h18, 32'h04);
      wr(5'h0C, 32'hFF);
      set_pins(8'h0C); idle(4);
      rd(5'h04, 32'h0C, "R5 rise");
      wr(5'h0C, 32'hFF);
      set_pins(8'h00); idle(4);
      rd(5'h04, 32'h0C, "R5 fall");

      // R6: level mode, any-transition bit ignored
      wr(5'h10, 32'h30);
      wr(5'h18, 32'h10);
      wr(5'h14, 32'hFF);
      wr(5'h0C, 32'hFF);
      idle(2);
      rd(5'h04, 32'h20, "R6 low level");
      wr(5'h0C, 32'h20);
      rd(5'h04, 32'h20, "R6 re-set after clear");
      set_pins(8'h30); idle(4);
      wr(5'h0C, 32'h30);
      idle(1);
      rd(5'h04, 32'h10, "R6 high level");

      // R7: clear semantics
      wr(5'h10, 32'h00);
      wr(5'h14, 32'h00);
      wr(5'h18, 32'hFF);
      set_pins(8'h00); idle(4);
      wr(5'h0C, 32'hFF);
      rd(5'h04, 32'h00, "R7 cleared");
      set_pins(8'h40); idle(4);
      rd(5'h04, 32'h40, "R3 rise ch6");
      wr(5'h0C, 32'hBF);
      rd(5'h04, 32'h40, "R7 zero bits keep status");
      rd(5'h0C, 32'h00, "R7 clear reads zero");
      // same-cycle clear and event: event wins
      @(negedge clk); #1;
      ext_in = 8'hC0;
      @(negedge clk);
      @(negedge clk); #1;
      bus_addr = 5'h0C; bus_wr = 1'b1; bus_wdata = 32'hC0;
      @(negedge clk); #1;
      bus_wr = 1'b0;
      rd(5'h04, 32'h80, "R7 event wins over clear");

      // R8: masking and interrupt
      wr(5'h00, 32'h80);
      rd(5'h08, 32'h80, "R8 masked on");
      chk_irq(1'b1, "R8 irq on");
      wr(5'h00, 32'hFFFFFF7F);
      rd(5'h08, 32'h00, "R8 masked off");
      chk_irq(1'b0, "R8 irq off");

      // R10: readback, ignored writes, unaligned access
      rd(5'h00, 32'h7F, "R10 upper bits zero");
      wr(5'h04, 32'hFF);
      rd(5'h04, 32'h80, "R10 raw write ignored");
      wr(5'h1C, 32'hFF);
      rd(5'h1C, 32'hC0, "R10 data write ignored");
      wr(5'h01, 32'hFF);
      rd(5'h00, 32'h7F, "R10 unaligned write ignored");
      rd(5'h01, 32'h00, "R10 unaligned read zero");
      rd(5'h10, 32'h00, "R10 mode readback");
      rd(5'h18, 32'hFF, "R10 polarity readback");

      idle(2);
      chk_on = 0;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule